// File: doc/BRIEF.md
# Interrupt Request Aggregator with Port-Change Wakeup

This block gathers five interrupt sources of a small microcontroller core into one request line and one wake-from-sleep line. Three sources sit in a core control register: a timer 0 overflow pulse, an edge on an external interrupt pin, and a change on any pin of the 8-bit port B. Two more sit in peripheral registers: a timer 1 overflow pulse and a change on any pin of the 8-bit port D. Each source has its own sticky flag and enable. The peripheral sources are also gated by a peripheral enable, and every source is gated by a global enable.

The core drives a small register bus: a 3-bit select, a write strobe, write data and combinational read data. It pulses an acknowledge when it takes the interrupt, which clears the global enable, and a return strobe when it leaves the handler, which sets it again. Port change detection compares the synchronized pins against a copy taken on each port read, so software ends a change event by reading the port and then clearing the flag.

Top module: `irq_hub`

## Requirements
- R1: After reset the control register reads 0x01, peripheral flag register 2 reads 0x80, and peripheral flag register 1 and both peripheral enable registers read 0x00; irq and wake are low.
- R2: Control register layout: bit 0 port B change flag, bit 1 external pin flag, bit 2 timer 0 flag, bits 3/4/5 the matching enables, bit 6 peripheral enable, bit 7 global enable; a t0_ovf pulse sets bit 2 at the next clock edge.
- R3: Peripheral flag/enable register 1 use only bit 0 (timer 1 overflow); peripheral flag/enable register 2 use only bit 7 (port D change); all other bits read 0 whatever is written.
- R4: irq is high exactly when the global enable is set and either some core flag is set with its enable, or the peripheral enable is set and some peripheral flag is set with its enable.
- R5: irq_ack clears the global enable at the next edge; reti sets it; if both arrive in one cycle, the clear wins.
- R6: The external pin flag sets on a rising edge of the synchronized pin when ext_rise is 1, and on a falling edge when ext_rise is 0; the other edge has no effect.
- R7: Each port's change flag sets while its two-stage synchronized pins differ from a copy latched on that port's read strobe; the flag is set within four cycles of the pin change.
- R8: Flags are cleared only by a software write of 0; a hardware set in the same cycle as that write wins.
- R9: wake is high when the port B change flag and its enable are both set, or the port D change flag and its enable are both set, regardless of the global and peripheral enables.
- R10: bus_sel encoding: 0 control, 1 peripheral flag 1, 2 peripheral flag 2, 3 peripheral enable 1, 4 peripheral enable 2; other values read 0x00 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| ext_rise | input | 1 | 1 selects rising edge, 0 falling edge |
| pb_pins | input | 8 | Port B pins, asynchronous |
| pb_rd | input | 1 | Port B read strobe, latches the compare copy |
| pd_pins | input | 8 | Port D pins, asynchronous |
| pd_rd | input | 1 | Port D read strobe, latches the compare copy |
| irq_ack | input | 1 | Interrupt taken, clears the global enable |
| reti | input | 1 | Return from handler, sets the global enable |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-from-sleep request |

## Verification
The request line is tried with each source alone under its own enable, with the enable cleared, and with the peripheral enable cleared, which separates a missing individual gate from a missing peripheral or global gate. The external pin is toggled in both directions under both edge selections, so a wrong polarity or a both-edge detector shows up. Port pins are changed and then left differing, so a flag cleared before the port read reappears, while one cleared after the read stays clear, telling latch-on-read from a plain edge detector. Same-cycle races (clear versus set, acknowledge versus return) fix the priorities.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_PF1  = 3'd1,
    SEL_PF2  = 3'd2,
    SEL_PE1  = 3'd3,
    SEL_PE2  = 3'd4
  } sel_e;

  localparam int unsigned B_PBF  = 0;
  localparam int unsigned B_EXF  = 1;
  localparam int unsigned B_T0F  = 2;
  localparam int unsigned B_PBE  = 3;
  localparam int unsigned B_EXE  = 4;
  localparam int unsigned B_T0E  = 5;
  localparam int unsigned B_PEIE = 6;
  localparam int unsigned B_GIE  = 7;
  localparam int unsigned B_T1   = 0;
  localparam int unsigned B_PD   = 7;
  localparam logic [7:0]  CTRL_RST = 8'h01;
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irq_hub_chg.sv
module irq_hub_chg #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         rd_stb,
  output logic         change
);
  logic [W-1:0] pin_s;
  logic [W-1:0] copy_q, copy_d;

  irq_hub_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pin_s)
  );

  always_comb begin
    copy_d = copy_q;
    if (rd_stb) copy_d = pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) copy_q <= '0;
    else        copy_q <= copy_d;
  end

  assign change = |(pin_s ^ copy_q);
endmodule

// File: rtl/irq_hub_edge.sv
module irq_hub_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic pin_s;
  logic prev_q;

  irq_hub_sync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  assign hit = rise_sel ? (pin_s & ~prev_q) : (~pin_s & prev_q);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              t0_ovf,
  input  logic              t1_ovf,
  input  logic              ext_pin,
  input  logic              ext_rise,
  input  logic [PORT_W-1:0] pb_pins,
  input  logic              pb_rd,
  input  logic [PORT_W-1:0] pd_pins,
  input  logic              pd_rd,
  input  logic              irq_ack,
  input  logic              reti,
  output logic              irq,
  output logic              wake
);
  logic [7:0] ctrl_q, ctrl_d;
  logic       t1f_q, t1f_d, pdf_q, pdf_d;
  logic       t1e_q, t1e_d, pde_q, pde_d;
  logic       pb_chg, pd_chg, ext_hit;
  logic       wr_ctrl, wr_pf1, wr_pf2, wr_pe1, wr_pe2;
  logic       core_hit, peri_hit;
  sel_e       sel;

  assign sel = sel_e'(bus_sel);

  irq_hub_chg #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_pb_chg (
    .clk(clk), .rst_n(rst_n), .pins(pb_pins), .rd_stb(pb_rd), .change(pb_chg)
  );

  irq_hub_chg #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_pd_chg (
    .clk(clk), .rst_n(rst_n), .pins(pd_pins), .rd_stb(pd_rd), .change(pd_chg)
  );

  irq_hub_edge #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(ext_rise), .hit(ext_hit)
  );

  assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
  assign wr_pf1  = bus_wr && (sel == SEL_PF1);
  assign wr_pf2  = bus_wr && (sel == SEL_PF2);
  assign wr_pe1  = bus_wr && (sel == SEL_PE1);
  assign wr_pe2  = bus_wr && (sel == SEL_PE2);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = bus_wdata;
    if (reti)    ctrl_d[B_GIE] = 1'b1;
    if (irq_ack) ctrl_d[B_GIE] = 1'b0;
    ctrl_d[B_PBF] = ctrl_d[B_PBF] | pb_chg;
    ctrl_d[B_EXF] = ctrl_d[B_EXF] | ext_hit;
    ctrl_d[B_T0F] = ctrl_d[B_T0F] | t0_ovf;

    t1f_d = (wr_pf1 ? bus_wdata[B_T1] : t1f_q) | t1_ovf;
    pdf_d = (wr_pf2 ? bus_wdata[B_PD] : pdf_q) | pd_chg;
    t1e_d = wr_pe1 ? bus_wdata[B_T1] : t1e_q;
    pde_d = wr_pe2 ? bus_wdata[B_PD] : pde_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      t1f_q  <= 1'b0;
      pdf_q  <= 1'b1;
      t1e_q  <= 1'b0;
      pde_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      t1f_q  <= t1f_d;
      pdf_q  <= pdf_d;
      t1e_q  <= t1e_d;
      pde_q  <= pde_d;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (sel)
      SEL_CTRL: bus_rdata = ctrl_q;
      SEL_PF1:  bus_rdata[B_T1] = t1f_q;
      SEL_PF2:  bus_rdata[B_PD] = pdf_q;
      SEL_PE1:  bus_rdata[B_T1] = t1e_q;
      SEL_PE2:  bus_rdata[B_PD] = pde_q;
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign core_hit = |(ctrl_q[B_T0F:B_PBF] & ctrl_q[B_T0E:B_PBE]);
  assign peri_hit = ctrl_q[B_PEIE] & ((t1f_q & t1e_q) | (pdf_q & pde_q));
  assign irq      = ctrl_q[B_GIE] & (core_hit | peri_hit);
  assign wake     = (ctrl_q[B_PBF] & ctrl_q[B_PBE]) | (pdf_q & pde_q);

  // R5
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq);
  // R5
  reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_ack) |=> (ctrl_q[B_GIE] == 1'b1));
  // R2
  t0_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t0_ovf |=> ctrl_q[B_T0F]);
  // R8
  pb_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_PBF] && !wr_ctrl) |=> ctrl_q[B_PBF]);
  // R8
  pd_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdf_q && !wr_pf2) |=> pdf_q);
  // R9
  wake_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (ctrl_q[B_PBF] || pdf_q));
endmodule

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_sel;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       t0_ovf, t1_ovf, ext_pin, ext_rise;
  logic [7:0] pb_pins, pd_pins;
  logic       pb_rd, pd_rd, irq_ack, reti;
  logic       irq, wake;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hub u_irq_hub (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .t0_ovf(t0_ovf),
    .t1_ovf(t1_ovf), .ext_pin(ext_pin), .ext_rise(ext_rise),
    .pb_pins(pb_pins), .pb_rd(pb_rd), .pd_pins(pd_pins), .pd_rd(pd_rd),
    .irq_ack(irq_ack), .reti(reti), .irq(irq), .wake(wake)
  );

  // monitor: pops expected items shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sb_q.pop_front();
        case (it.kind)
          0:       got = bus_rdata;
          1:       got = {7'd0, irq};
          default: got = {7'd0, wake};
        endcase
        n_run++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: kind %0d got %h expected %h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic exp_reg(input logic [2:0] sel, input logic [7:0] e, input string req);
    item_t it;
    bus_sel = sel;
    it.kind = 0; it.exp = e; it.req = req;
    sb_q.push_back(it);
    tick(1);
  endtask

  task automatic exp_pin(input int kind, input logic e, input string req);
    item_t it;
    it.kind = kind; it.exp = {7'd0, e}; it.req = req;
    sb_q.push_back(it);
    tick(1);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    tick(1);
    s = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 3'd0; bus_wr = 1'b0; bus_wdata = 8'h00;
    t0_ovf = 0; t1_ovf = 0; ext_pin = 0; ext_rise = 1;
    pb_pins = 8'h00; pd_pins = 8'h00; pb_rd = 0; pd_rd = 0;
    irq_ack = 0; reti = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    exp_reg(3'd0, 8'h01, "R1 ctrl");
    exp_reg(3'd1, 8'h00, "R1 pf1");
    exp_reg(3'd2, 8'h80, "R1 pf2");
    exp_reg(3'd3, 8'h00, "R1 pe1");
    exp_reg(3'd4, 8'h00, "R1 pe2");
    exp_pin(1, 1'b0, "R1 irq");
    exp_pin(2, 1'b0, "R1 wake");
    // R10 unused select
    exp_reg(3'd5, 8'h00, "R10 unused select");
    wr(3'd6, 8'hFF);
    exp_reg(3'd0, 8'h01, "R10 write to unused select");

    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    exp_reg(3'd0, 8'h00, "R8 ctrl cleared by write");
    exp_reg(3'd2, 8'h00, "R8 pf2 cleared by write");

    // R2 R4 timer 0
    wr(3'd0, 8'hA0);
    pulse(t0_ovf);
    exp_reg(3'd0, 8'hA4, "R2 t0 flag");
    exp_pin(1, 1'b1, "R4 t0 irq");
    // R5
    pulse(irq_ack);
    exp_reg(3'd0, 8'h24, "R5 ack clears gie");
    exp_pin(1, 1'b0, "R5 irq after ack");
    pulse(reti);
    exp_reg(3'd0, 8'hA4, "R5 reti sets gie");
    exp_pin(1, 1'b1, "R5 irq after reti");
    irq_ack = 1; reti = 1;
    tick(1);
    irq_ack = 0; reti = 0;
    exp_reg(3'd0, 8'h24, "R5 ack beats reti");

    // R4 masked flag
    wr(3'd0, 8'h80);
    pulse(t0_ovf);
    exp_reg(3'd0, 8'h84, "R4 masked t0 flag");
    exp_pin(1, 1'b0, "R4 masked t0 irq");
    // R8 set beats clear
    bus_sel = 3'd0; bus_wdata = 8'h80; bus_wr = 1; t0_ovf = 1;
    tick(1);
    bus_wr = 0; t0_ovf = 0;
    exp_reg(3'd0, 8'h84, "R8 set beats clear");

    // R6 external edge
    wr(3'd0, 8'h90);
    ext_pin = 1; tick(4);
    exp_reg(3'd0, 8'h92, "R6 rising edge selected");
    exp_pin(1, 1'b1, "R4 ext irq");
    wr(3'd0, 8'h90);
    ext_pin = 0; tick(4);
    exp_reg(3'd0, 8'h90, "R6 falling ignored");
    ext_rise = 0;
    ext_pin = 1; tick(4);
    exp_reg(3'd0, 8'h90, "R6 rising ignored");
    ext_pin = 0; tick(4);
    exp_reg(3'd0, 8'h92, "R6 falling edge selected");

    // R7 R9 port B
    wr(3'd0, 8'h08);
    pb_pins = 8'h05; tick(4);
    exp_reg(3'd0, 8'h09, "R7 pb change flag");
    exp_pin(1, 1'b0, "R4 no gie no irq");
    exp_pin(2, 1'b1, "R9 pb wake");
    wr(3'd0, 8'h08);
    exp_reg(3'd0, 8'h09, "R7 flag resets before read");
    pulse(pb_rd);
    wr(3'd0, 8'h08);
    tick(2);
    exp_reg(3'd0, 8'h08, "R7 flag stays clear after read");
    exp_pin(2, 1'b0, "R9 wake low");

    // R9 port D
    wr(3'd4, 8'h80);
    wr(3'd0, 8'hC0);
    pd_pins = 8'h10; tick(4);
    exp_reg(3'd2, 8'h80, "R7 pd change flag");
    exp_pin(1, 1'b1, "R4 pd irq");
    exp_pin(2, 1'b1, "R9 pd wake");
    wr(3'd0, 8'h80);
    exp_pin(1, 1'b0, "R4 peripheral enable off");
    exp_pin(2, 1'b1, "R9 wake ignores enables");
    pulse(pd_rd);
    wr(3'd2, 8'h00);
    exp_reg(3'd2, 8'h00, "R7 pd cleared after read");
    exp_pin(2, 1'b0, "R9 wake low after pd clear");

    // R3 timer 1
    wr(3'd3, 8'h01);
    wr(3'd0, 8'hC0);
    pulse(t1_ovf);
    exp_reg(3'd1, 8'h01, "R3 t1 flag");
    exp_pin(1, 1'b1, "R4 t1 irq");
    wr(3'd1, 8'h00);
    exp_pin(1, 1'b0, "R8 t1 cleared");

    // R3 unimplemented bits
    wr(3'd2, 8'hFF);
    exp_reg(3'd2, 8'h80, "R3 pf2 other bits zero");
    wr(3'd4, 8'h7F);
    exp_reg(3'd4, 8'h00, "R3 pe2 other bits zero");
    wr(3'd3, 8'hFE);
    exp_reg(3'd3, 8'h00, "R3 pe1 other bits zero");

    tick(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule